// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI controller from the core clock and produces the single-cycle edge strobes that a separate shifter uses to sample and to launch data. The division ratio comes from an 8-bit prescale setting. A parameter selects one of two encodings for that setting. The extended encoding is a 4-bit mantissa times a power of two, with a 3-bit exponent whose bits are not next to each other in the field. The legacy encoding is a simple even ratio from 4 to 30.

While no transfer runs, the counter stays at zero and the serial clock rests at the clock-polarity idle level. Once the run input rises, each period of the serial clock starts with the idle-level half, followed by the opposite-level half. A new prescale value reaches the counter only when a period ends and the shifter has marked that period as the last one of a word. A setting written in the middle of a word therefore never changes a clock period in flight.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: In the extended encoding the ratio is mantissa << exponent. The mantissa is prescale[3:0]. The exponent is {prescale[7], prescale[6], prescale[4]}, with bit 4 as the least significant bit. prescale[5] has no effect.
- R2: In the extended encoding a mantissa of 0 or 1 acts as 2, so the ratio is never below 2.
- R3: In the legacy encoding the ratio is 2 × prescale[3:0], and values of prescale[3:0] below 2 act as 2, which gives a ratio of 4. prescale[7:4] has no effect.
- R4: While run is low, sclk equals cpol from the next cycle on, all four strobes stay low, and the counter restarts. The first leading edge then appears exactly ceil(ratio/2) cycles after run is first sampled high.
- R5: Each period lasts exactly ratio core cycles. sclk stays at the idle level for ceil(ratio/2) cycles and at the opposite level for floor(ratio/2) cycles, so for an odd ratio the non-idle half is one cycle shorter.
- R6: lead_stb and trail_stb are each high for one cycle, in the first cycle in which sclk shows its new level. lead_stb marks the change away from idle and trail_stb marks the return to idle. The two are never high together.
- R7: With cpha=0, sample_stb equals lead_stb and shift_stb equals trail_stb. With cpha=1, sample_stb equals trail_stb and shift_stb equals lead_stb.
- R8: A transfer uses the prescale value present in the last idle cycle. A change during the run takes effect only in the period after one that ends while word_last is high.
- R9: During reset, sclk and all strobes are low.
- R10: The extended setting 0xDF gives the largest ratio, 1920 (15 × 2^7), with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_i | input | 8 | Prescale setting in the encoding chosen by ENC |
| cpol_i | input | 1 | Idle level of sclk |
| cpha_i | input | 1 | Selects which edge samples data |
| run_i | input | 1 | High while a transfer is in progress |
| word_last_i | input | 1 | Current period is the last one of a word |
| sclk_o | output | 1 | Divided serial clock |
| lead_stb_o | output | 1 | sclk has just left the idle level |
| trail_stb_o | output | 1 | sclk has just returned to the idle level |
| sample_stb_o | output | 1 | Sample the input data in this cycle |
| shift_stb_o | output | 1 | Launch the next output bit in this cycle |

## Verification
The assertions check on every cycle the relations that hold regardless of the ratio. They cover the idle level and quiet strobes while run is low, strobes that always coincide with an sclk change and never overlap, the mapping from cpha to the sample and shift strobes, and the non-idle level after a leading edge. Ratio decoding, the exact lengths of the two halves, the clamping of small mantissas, the 1920 ratio and the point at which a new setting is applied all depend on the setting's value and timing. Only the bench's sweeps show those, and it compares each cycle against a period computed from the encoding rules.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;
  typedef enum logic {ENC_LEGACY = 1'b0, ENC_EXTENDED = 1'b1} enc_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_s;
endpackage

// File: rtl/spi_psc_decode.sv
module spi_psc_decode
  import spi_psc_pkg::*;
#(
  parameter enc_e ENC     = ENC_EXTENDED,
  parameter int   PS_W    = 8,
  parameter int   MANT_W  = 4,
  parameter int   EXP_W   = 3,
  parameter int   RATIO_W = MANT_W + (2 ** EXP_W) - 1
) (
  input  logic [PS_W-1:0]    ps,
  output logic [RATIO_W-1:0] ratio
);
  localparam int EXP_LO_POS = MANT_W;
  localparam int EXP_HI_POS = MANT_W + 2;

  logic [MANT_W-1:0] mant;
  logic [MANT_W-1:0] mant_eff;

  assign mant     = ps[MANT_W-1:0];
  assign mant_eff = (mant < MANT_W'(2)) ? MANT_W'(2) : mant;

  generate
    if (ENC == ENC_EXTENDED) begin : g_ext
      logic [EXP_W-1:0] expo;
      assign expo  = {ps[EXP_HI_POS +: EXP_W-1], ps[EXP_LO_POS]};
      assign ratio = RATIO_W'(mant_eff) << expo;
    end else begin : g_leg
      assign ratio = RATIO_W'({mant_eff, 1'b0});
    end
  endgenerate
endmodule

// File: rtl/spi_psc_ratio_reg.sv
module spi_psc_ratio_reg #(
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RATIO_W-1:0] ratio_d,
  output logic [RATIO_W-1:0] ratio_q
);
  always_ff @(posedge clk) begin
    if (rst)       ratio_q <= RATIO_W'(4);
    else if (load) ratio_q <= ratio_d;
  end
endmodule

// File: rtl/spi_psc_edge_gen.sv
module spi_psc_edge_gen
  import spi_psc_pkg::*;
#(
  parameter int RATIO_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sclk,
  output edge_s              edges,
  output logic               sample,
  output logic               shift,
  output logic               period_end
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] idle_len;
  logic               at_lead;

  assign idle_len   = ratio - (ratio >> 1);
  assign at_lead    = (cnt == idle_len - RATIO_W'(1));
  assign period_end = (cnt == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sclk   <= 1'b0;
      edges  <= '0;
      sample <= 1'b0;
      shift  <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk   <= cpol;
      edges  <= '0;
      sample <= 1'b0;
      shift  <= 1'b0;
    end else begin
      edges.lead  <= at_lead;
      edges.trail <= period_end;
      sample      <= cpha ? period_end : at_lead;
      shift       <= cpha ? at_lead : period_end;
      if (period_end) begin
        cnt  <= '0;
        sclk <= cpol;
      end else begin
        cnt <= cnt + RATIO_W'(1);
        if (at_lead) sclk <= ~cpol;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_psc_pkg::*;
#(
  parameter enc_e ENC    = ENC_EXTENDED,
  parameter int   PS_W   = 8,
  parameter int   MANT_W = 4,
  parameter int   EXP_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] prescale_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic            run_i,
  input  logic            word_last_i,
  output logic            sclk_o,
  output logic            lead_stb_o,
  output logic            trail_stb_o,
  output logic            sample_stb_o,
  output logic            shift_stb_o
);
  localparam int RATIO_W = MANT_W + (2 ** EXP_W) - 1;

  logic [RATIO_W-1:0] ratio_d;
  logic [RATIO_W-1:0] ratio_q;
  logic               period_end;
  logic               load;
  edge_s              edges;

  spi_psc_decode #(
    .ENC(ENC), .PS_W(PS_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .RATIO_W(RATIO_W)
  ) u_decode (
    .ps(prescale_i), .ratio(ratio_d)
  );

  assign load = !run_i || (word_last_i && period_end);

  spi_psc_ratio_reg #(.RATIO_W(RATIO_W)) u_ratio (
    .clk(clk), .rst(rst), .load(load), .ratio_d(ratio_d), .ratio_q(ratio_q)
  );

  spi_psc_edge_gen #(.RATIO_W(RATIO_W)) u_edge (
    .clk(clk), .rst(rst), .run(run_i), .cpol(cpol_i), .cpha(cpha_i),
    .ratio(ratio_q), .sclk(sclk_o), .edges(edges), .sample(sample_stb_o),
    .shift(shift_stb_o), .period_end(period_end)
  );

  assign lead_stb_o  = edges.lead;
  assign trail_stb_o = edges.trail;
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
  input logic clk,
  input logic rst,
  input logic cpol_i,
  input logic cpha_i,
  input logic run_i,
  input logic sclk_o,
  input logic lead_stb_o,
  input logic trail_stb_o,
  input logic sample_stb_o,
  input logic shift_stb_o
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (sclk_o == $past(cpol_i)) && !lead_stb_o && !trail_stb_o) else $error("idle"); // R4
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    (sample_stb_o || shift_stb_o) |-> $past(run_i)) else $error("stray"); // R4
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_stb_o, trail_stb_o})) else $error("excl"); // R6
  AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (lead_stb_o || trail_stb_o) |-> !$stable(sclk_o)) else $error("toggle"); // R6
  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    lead_stb_o |-> (sclk_o != $past(cpol_i))) else $error("lead"); // R5
  AST_CPHA_MAP: assert property (@(posedge clk) disable iff (rst)
    (lead_stb_o || trail_stb_o) |->
      (sample_stb_o == ($past(cpha_i) ? trail_stb_o : lead_stb_o)) &&
      (shift_stb_o  == ($past(cpha_i) ? lead_stb_o : trail_stb_o))) else $error("cpha"); // R7
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk u_chk (
  .clk(clk), .rst(rst), .cpol_i(cpol_i), .cpha_i(cpha_i), .run_i(run_i),
  .sclk_o(sclk_o), .lead_stb_o(lead_stb_o), .trail_stb_o(trail_stb_o),
  .sample_stb_o(sample_stb_o), .shift_stb_o(shift_stb_o)
);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;
  import spi_psc_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] prescale = 8'h04;
  logic       cpol = 1'b0, cpha = 1'b0, run = 1'b0, word_last = 1'b0;
  logic       sclk_e, lead_e, trail_e, samp_e, shft_e;
  logic       sclk_l, lead_l, trail_l, samp_l, shft_l;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_prescaler #(.ENC(ENC_EXTENDED)) u_dut (
    .clk(clk), .rst(rst), .prescale_i(prescale), .cpol_i(cpol), .cpha_i(cpha),
    .run_i(run), .word_last_i(word_last), .sclk_o(sclk_e), .lead_stb_o(lead_e),
    .trail_stb_o(trail_e), .sample_stb_o(samp_e), .shift_stb_o(shft_e)
  );

  spi_sclk_prescaler #(.ENC(ENC_LEGACY)) u_dut_legacy (
    .clk(clk), .rst(rst), .prescale_i(prescale), .cpol_i(cpol), .cpha_i(cpha),
    .run_i(run), .word_last_i(word_last), .sclk_o(sclk_l), .lead_stb_o(lead_l),
    .trail_stb_o(trail_l), .sample_stb_o(samp_l), .shift_stb_o(shft_l)
  );

  function automatic int ext_ratio(input logic [7:0] p);
    int m;
    int e;
    m = (p[3:0] < 2) ? 2 : int'(p[3:0]);
    e = int'({p[7], p[6], p[4]});
    return m << e;
  endfunction

  function automatic int leg_ratio(input logic [7:0] p);
    return 2 * ((p[3:0] < 2) ? 2 : int'(p[3:0]));
  endfunction

  // Samples nsmp cycles after a period start; sel=1 observes the legacy instance.
  task automatic span(input int r, input int nsmp, input bit sel, input string req);
    int  q;
    int  lo;
    int  bad;
    logic [4:0] got;
    logic [4:0] expv;
    bad = 0;
    lo  = r - r / 2;
    for (int n = 0; n < nsmp; n++) begin
      @(negedge clk);
      q = n % r;
      expv[4] = (q >= lo - 1 && q < r - 1) ? ~cpol : cpol;
      expv[3] = (q == lo - 1);
      expv[2] = (q == r - 1);
      expv[1] = cpha ? expv[2] : expv[3];
      expv[0] = cpha ? expv[3] : expv[2];
      got = sel ? {sclk_l, lead_l, trail_l, samp_l, shft_l}
                : {sclk_e, lead_e, trail_e, samp_e, shft_e};
      if (got !== expv && bad == 0) begin
        $display("FAIL %s ratio %0d cycle %0d actual %b expected %b (sclk,lead,trail,sample,shift)",
                 req, r, n, got, expv);
        bad = 1;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic start(input logic [7:0] p, input bit cp, input bit ch);
    @(negedge clk);
    run = 1'b0; prescale = p; cpol = cp; cpha = ch;
    repeat (2) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic check_idle(input string req);
    logic [4:0] got;
    @(negedge clk);
    got = {sclk_e, lead_e, trail_e, samp_e, shft_e};
    checks++;
    if (got !== {cpol, 4'b0000}) begin
      errors++;
      $display("FAIL %s idle actual %b expected %b", req, got, {cpol, 4'b0000});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if ({sclk_e, lead_e, trail_e, samp_e, shft_e} !== 5'b0) begin
      errors++;
      $display("FAIL R9 reset actual %b expected 00000", {sclk_e, lead_e, trail_e, samp_e, shft_e});
    end
    rst = 1'b0;
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R4");

    // R1 R2 R4 R5 R6 R7: extended sweep, bit 5 toggled to show it is ignored
    for (int cp = 0; cp < 2; cp++)
      for (int ch = 0; ch < 2; ch++)
        for (int e = 0; e < 5; e++)
          for (int m = 0; m < 16; m++) begin
            logic [7:0] p;
            p = {e[2], e[1], m[0], e[0], m[3:0]};
            start(p, cp[0], ch[0]);
            span(ext_ratio(p), 2 * ext_ratio(p), 1'b0, (m < 2) ? "R2" : "R1/R5");
          end
    run = 1'b0;
    check_idle("R4");

    // R10: largest ratio
    start(8'hDF, 1'b0, 1'b1);
    span(1920, 3840, 1'b0, "R10");
    // R2: mantissa 1 with exponent 4 gives 32
    start(8'h81, 1'b1, 1'b0);
    span(32, 64, 1'b0, "R2");

    // R3: legacy sweep, bit 4 toggled to show it is ignored
    for (int x = 0; x < 32; x++) begin
      logic [7:0] p;
      p = {3'b010, x[4:0]};
      start(p, x[0], x[1]);
      span(leg_ratio(p), 2 * leg_ratio(p), 1'b1, "R3");
    end

    // R8: mid-word change ignored until a period ending with word_last
    start(8'h04, 1'b0, 1'b0);
    prescale = 8'h06;
    span(4, 8, 1'b0, "R8 mid-word hold");
    word_last = 1'b1;
    span(4, 4, 1'b0, "R8 last period");
    word_last = 1'b0;
    span(6, 12, 1'b0, "R8 new ratio");
    run = 1'b0;
    @(negedge clk);
    check_idle("R4");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule